// File: doc/BRIEF.md
# Three-Phase Reset-Synchronized PWM Generator

This block drives three complementary phase pairs from one up-counter. The counter runs from zero up to a programmed period value and clears to zero on the clock after it reaches that value, so all three phases share one cycle. Each phase has its own compare value. The positive output of a phase is active while the counter is below that compare value. The negative output carries the opposite active state. Two polarity bits set the active level of the positive group and of the negative group. Each of the six pins has its own enable bit. A pin that is switched off drives its inactive level. An optional toggle output flips once per PWM cycle.

Software-style setup goes through a single write port with an address and a data word. A start bit in the control register runs the count, and clearing that bit halts it. All other registers, including a counter-clear strobe, accept writes only while the counter is halted. Writes to them while it runs are dropped. The control path is a two-state machine. `ST_HALT` moves to `ST_RUN` when the control register is written with bit 0 set. `ST_RUN` moves back to `ST_HALT` when the control register is written with bit 0 clear. Any other write leaves the state where it is. Compare values above the period are not supported. The data width must be at least 6 bits.

Top module: `pwm3_gen`

## Requirements
- R1: While running, the counter rises by one on each clock. In the clock after it equals the period register (address 1), it reads zero. A period of 0 keeps it at zero.
- R2: The positive pin of phase k (duty register at address 2+k) is active exactly while the counter is below that duty value. A duty of 0 is never active. A duty equal to the period is active on every count except the period itself.
- R3: The negative pin of each phase is active exactly when its positive pin is not.
- R4: Mode register (address 5). Bit 0 set makes the positive pins active-high and clear makes them active-low. Bit 1 does the same for the negative pins.
- R5: Pin-enable register (address 6). Bit k enables positive pin k and bit 3+k enables negative pin k. A disabled pin drives its inactive level.
- R6: With mode bit 2 set, `cyc_tog` shows a toggle state that flips on every clock edge where the running counter clears from the period to zero. With bit 2 clear, `cyc_tog` is 0.
- R7: Writing address 0 with bit 0 set starts counting from the next clock. Writing it with bit 0 clear halts the counter. While halted, the counter holds its value and `running` is 0.
- R8: While running, writes to addresses 1 to 7 have no effect on the period, the duties, the mode, the pin enables or the counter.
- R9: A write to address 7 while halted sets the counter to zero.
- R10: After reset the counter is 0, the block is halted, the toggle state is 0, both polarities are active-high, all pins are disabled, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_p | output | 3 | Positive-phase pins, one per phase |
| pwm_n | output | 3 | Negative-phase pins, one per phase |
| cyc_tog | output | 1 | Cycle toggle output |
| cnt_val | output | CNT_W | Current counter value |
| running | output | 1 | High in the run state |

## Verification
The assertions check the following on every cycle:
- the counter increments and wraps at the period;
- the counter holds while halted;
- each registered phase state agrees with the counter and duty compare;
- complementary pairs stay opposite under equal polarity;
- disabled pins sit at their inactive level;
- the duty and period registers stay frozen while running;
- the toggle flips on each wrap.

The bench scenarios cover the rest:
- a sweep over every duty from 0 to the period, including duty equal to the period;
- every polarity and a range of enable patterns, with exact pin levels compared against an arithmetic model;
- a toggle history that carries across runs;
- the exact cycle on which counting starts after the start write;
- dropped writes during a run;
- the effect of the clear strobe.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_PER   = 3'd1;
    localparam logic [2:0] ADR_DUTY0 = 3'd2;
    localparam logic [2:0] ADR_MODE  = 3'd5;
    localparam logic [2:0] ADR_PINEN = 3'd6;
    localparam logic [2:0] ADR_CLR   = 3'd7;

    localparam int MODE_POL_P = 0;
    localparam int MODE_POL_N = 1;
    localparam int MODE_TOG   = 2;

endpackage

// File: rtl/pwm3_regs.sv
`timescale 1ns/1ps
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_PH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [2:0]                   wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         locked,
    output logic [CNT_W-1:0]             per_q,
    output logic [NUM_PH-1:0][CNT_W-1:0] duty_q,
    output logic [NUM_PH-1:0][CNT_W-1:0] duty_nxt,
    output logic                         pol_p,
    output logic                         pol_n,
    output logic                         tog_en,
    output logic [NUM_PH-1:0]            en_p,
    output logic [NUM_PH-1:0]            en_n,
    output logic                         start_wr,
    output logic                         start_val,
    output logic                         clr_wr
);

    localparam int PIN_N = 2 * NUM_PH;

    logic             cfg_wr;
    logic [CNT_W-1:0] per_nxt;
    logic [2:0]       mode_q;
    logic [2:0]       mode_nxt;
    logic [PIN_N-1:0] pinen_q;
    logic [PIN_N-1:0] pinen_nxt;

    // Configuration writes are only taken while halted.
    assign cfg_wr    = wr_en && !locked;
    assign start_wr  = wr_en && (wr_addr == ADR_CTRL);
    assign start_val = wr_data[0];
    assign clr_wr    = cfg_wr && (wr_addr == ADR_CLR);

    always_comb begin
        per_nxt   = per_q;
        mode_nxt  = mode_q;
        pinen_nxt = pinen_q;
        if (cfg_wr && (wr_addr == ADR_PER))   per_nxt   = wr_data;
        if (cfg_wr && (wr_addr == ADR_MODE))  mode_nxt  = wr_data[2:0];
        if (cfg_wr && (wr_addr == ADR_PINEN)) pinen_nxt = wr_data[PIN_N-1:0];
    end

    for (genvar k = 0; k < NUM_PH; k++) begin : g_duty
        localparam logic [2:0] MY_ADR = ADR_DUTY0 + 3'(k);
        assign duty_nxt[k] = (cfg_wr && (wr_addr == MY_ADR)) ? wr_data : duty_q[k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) duty_q[k] <= '0;
            else        duty_q[k] <= duty_nxt[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q   <= '0;
            mode_q  <= 3'b011;
            pinen_q <= '0;
        end else begin
            per_q   <= per_nxt;
            mode_q  <= mode_nxt;
            pinen_q <= pinen_nxt;
        end
    end

    assign pol_p  = mode_q[MODE_POL_P];
    assign pol_n  = mode_q[MODE_POL_N];
    assign tog_en = mode_q[MODE_TOG];
    assign en_p   = pinen_q[NUM_PH-1:0];
    assign en_n   = pinen_q[PIN_N-1:NUM_PH];

endmodule

// File: rtl/pwm3_cnt.sv
`timescale 1ns/1ps
module pwm3_cnt
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             start_val,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             running,
    output logic             tog_q
);

    run_state_e state_q;
    run_state_e state_nxt;
    logic       wrap;

    // Next-state logic.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_HALT: if (start_wr && start_val)  state_nxt = ST_RUN;
            ST_RUN:  if (start_wr && !start_val) state_nxt = ST_HALT;
            default: state_nxt = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_nxt;
    end

    assign wrap = (state_q == ST_RUN) && (cnt_q == per_q);

    // Counter next value per state.
    always_comb begin
        cnt_nxt = cnt_q;
        unique case (state_q)
            ST_RUN:  cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
            ST_HALT: cnt_nxt = clr_wr ? '0 : cnt_q;
            default: cnt_nxt = cnt_q;
        endcase
    end

    // Counter and toggle registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            tog_q <= tog_q ^ wrap;
        end
    end

    assign running = (state_q == ST_RUN);

endmodule

// File: rtl/pwm3_phase.sv
`timescale 1ns/1ps
module pwm3_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] duty_nxt,
    input  logic             pol_p,
    input  logic             pol_n,
    input  logic             en_p,
    input  logic             en_n,
    output logic             raw_q,
    output logic             pin_p,
    output logic             pin_n
);

    // The compare is taken on next values, so raw_q tracks cnt_q < duty_q
    // and changes on the same edge as the counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= (cnt_nxt < duty_nxt);
    end

    always_comb begin
        pin_p = ~pol_p;
        pin_n = ~pol_n;
        if (en_p) pin_p = raw_q  ? pol_p : ~pol_p;
        if (en_n) pin_n = !raw_q ? pol_n : ~pol_n;
    end

endmodule

// File: rtl/pwm3_gen.sv
`timescale 1ns/1ps
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_PH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_PH-1:0] pwm_p,
    output logic [NUM_PH-1:0] pwm_n,
    output logic              cyc_tog,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              running
);

    logic [CNT_W-1:0]             per_q;
    logic [NUM_PH-1:0][CNT_W-1:0] duty_q;
    logic [NUM_PH-1:0][CNT_W-1:0] duty_nxt;
    logic                         pol_p;
    logic                         pol_n;
    logic                         tog_en;
    logic [NUM_PH-1:0]            en_p;
    logic [NUM_PH-1:0]            en_n;
    logic                         start_wr;
    logic                         start_val;
    logic                         clr_wr;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             cnt_nxt;
    logic                         tog_q;
    logic [NUM_PH-1:0]            raw_q;

    pwm3_regs #(.CNT_W(CNT_W), .NUM_PH(NUM_PH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .locked    (running),
        .per_q     (per_q),
        .duty_q    (duty_q),
        .duty_nxt  (duty_nxt),
        .pol_p     (pol_p),
        .pol_n     (pol_n),
        .tog_en    (tog_en),
        .en_p      (en_p),
        .en_n      (en_n),
        .start_wr  (start_wr),
        .start_val (start_val),
        .clr_wr    (clr_wr)
    );

    pwm3_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_val (start_val),
        .clr_wr    (clr_wr),
        .per_q     (per_q),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .running   (running),
        .tog_q     (tog_q)
    );

    for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
        pwm3_phase #(.CNT_W(CNT_W)) phase_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_nxt  (cnt_nxt),
            .duty_nxt (duty_nxt[k]),
            .pol_p    (pol_p),
            .pol_n    (pol_n),
            .en_p     (en_p[k]),
            .en_n     (en_n[k]),
            .raw_q    (raw_q[k]),
            .pin_p    (pwm_p[k]),
            .pin_n    (pwm_n[k])
        );
    end

    assign cyc_tog = tog_en & tog_q;
    assign cnt_val = cnt_q;

endmodule

// File: rtl/pwm3_gen_chk.sv
`timescale 1ns/1ps
module pwm3_gen_chk
    import pwm3_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_PH = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [2:0]                   wr_addr,
    input logic                         running,
    input logic [CNT_W-1:0]             cnt_q,
    input logic [CNT_W-1:0]             per_q,
    input logic [NUM_PH-1:0][CNT_W-1:0] duty_q,
    input logic [NUM_PH-1:0]            raw_q,
    input logic                         pol_p,
    input logic                         pol_n,
    input logic                         tog_en,
    input logic [NUM_PH-1:0]            en_p,
    input logic [NUM_PH-1:0]            en_n,
    input logic [NUM_PH-1:0]            pwm_p,
    input logic [NUM_PH-1:0]            pwm_n,
    input logic                         cyc_tog
);

    a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_q != per_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_q == per_q) |=> cnt_q == '0);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(cnt_q));

    a_r8_per_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && wr_addr == ADR_PER) |=> $stable(per_q));

    a_r8_duty_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(duty_q));

    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_q == per_q && tog_en) |=> cyc_tog != $past(cyc_tog));

    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_en |-> !cyc_tog);

    for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
        a_r2_duty: assert property (@(posedge clk) disable iff (!rst_n)
            raw_q[k] == (cnt_q < duty_q[k]));

        a_r3_pair: assert property (@(posedge clk) disable iff (!rst_n)
            (en_p[k] && en_n[k] && pol_p == pol_n) |-> pwm_p[k] != pwm_n[k]);

        a_r5_off_p: assert property (@(posedge clk) disable iff (!rst_n)
            !en_p[k] |-> pwm_p[k] == !pol_p);

        a_r5_off_n: assert property (@(posedge clk) disable iff (!rst_n)
            !en_n[k] |-> pwm_n[k] == !pol_n);
    end

endmodule

bind pwm3_gen pwm3_gen_chk #(.CNT_W(CNT_W), .NUM_PH(NUM_PH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .running (running),
    .cnt_q   (cnt_q),
    .per_q   (per_q),
    .duty_q  (duty_q),
    .raw_q   (raw_q),
    .pol_p   (pol_p),
    .pol_n   (pol_n),
    .tog_en  (tog_en),
    .en_p    (en_p),
    .en_n    (en_n),
    .pwm_p   (pwm_p),
    .pwm_n   (pwm_n),
    .cyc_tog (cyc_tog)
);

// File: tb/pwm3_gen_tb_top.sv
`timescale 1ns/1ps
module pwm3_gen_tb_top;

    localparam int CNT_W  = 6;
    localparam int NUM_PH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [NUM_PH-1:0] pwm_p;
    logic [NUM_PH-1:0] pwm_n;
    logic              cyc_tog;
    logic [CNT_W-1:0]  cnt_val;
    logic              running;

    int n_run = 0;
    int n_fail = 0;

    // Bench model state
    int   m = 0;
    logic tog_s = 1'b0;
    int   cper = 0;
    int   cd[3] = '{0, 0, 0};
    logic cpp = 1'b1, cpn = 1'b1, ctog = 1'b0;
    logic [5:0] cen = '0;

    always #4 clk = ~clk;

    pwm3_gen #(.CNT_W(CNT_W), .NUM_PH(NUM_PH)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_p   (pwm_p),
        .pwm_n   (pwm_n),
        .cyc_tog (cyc_tog),
        .cnt_val (cnt_val),
        .running (running)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One running clock edge in the model.
    task automatic step();
        if (m == cper) begin
            m = 0;
            tog_s = ~tog_s;
        end else begin
            m = m + 1;
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d[CNT_W-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check_all(input string tag, input int exp_run);
        chk({tag, " R1 counter"}, int'(cnt_val), m);
        chk({tag, " R7 running"}, int'(running), exp_run);
        for (int k = 0; k < NUM_PH; k++) begin
            logic raw, ep, en;
            raw = (m < cd[k]);
            ep = cen[k]     ? (raw  ? cpp : !cpp) : !cpp;
            en = cen[3 + k] ? (!raw ? cpn : !cpn) : !cpn;
            chk({tag, " R2/R4/R5 pos pin"}, int'(pwm_p[k]), int'(ep));
            chk({tag, " R3/R4/R5 neg pin"}, int'(pwm_n[k]), int'(en));
        end
        chk({tag, " R6 toggle"}, int'(cyc_tog), ctog ? int'(tog_s) : 0);
    endtask

    task automatic configure(input int per, input int d0, input int d1, input int d2,
                             input int mode, input int pen);
        cper = per; cd[0] = d0; cd[1] = d1; cd[2] = d2;
        cpp = mode[0]; cpn = mode[1]; ctog = mode[2];
        cen = pen[5:0];
        wr(3'd1, per);
        wr(3'd2, d0);
        wr(3'd3, d1);
        wr(3'd4, d2);
        wr(3'd5, mode);
        wr(3'd6, pen);
        wr(3'd7, 0);   // R9 clear before start
        m = 0;
    endtask

    task automatic run_chk(input int n, input string tag);
        wr(3'd0, 1);   // R7 start; counter still 0 after this edge
        for (int i = 0; i < n; i++) begin
            check_all(tag, 1);
            if (i < n - 1) begin
                @(negedge clk);
                step();
            end
        end
    endtask

    task automatic halt();
        wr(3'd0, 0);
        step();        // counter still advanced on the halting edge
    endtask

    task automatic main_seq();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 cnt", int'(cnt_val), 0);
        chk("R10 running", int'(running), 0);
        chk("R10 pwm_p", int'(pwm_p), 0);
        chk("R10 pwm_n", int'(pwm_n), 0);
        chk("R10 toggle", int'(cyc_tog), 0);

        // R2 sweep: every duty from 0 to the period
        for (int per = 0; per <= 9; per++) begin
            for (int d = 0; d <= per; d++) begin
                configure(per, d, (d + 1) % (per + 1), per - d,
                          3 | ((per & 1) << 2), 6'h3F);
                run_chk(2 * (per + 1) + 1, "R2 sweep");
                halt();
            end
        end

        // R4/R5 polarity and enable patterns
        for (int pol = 0; pol < 4; pol++) begin
            for (int e = 0; e < 6; e++) begin
                int pat;
                case (e)
                    0: pat = 6'h3F;
                    1: pat = 6'h00;
                    2: pat = 6'h15;
                    3: pat = 6'h2A;
                    4: pat = 6'h07;
                    default: pat = 6'h38;
                endcase
                configure(4, 0, 2, 4, pol | ((e & 1) << 2), pat);
                run_chk(11, "R4 R5 pol/en");
                halt();
            end
        end

        // R8 writes while running are dropped
        configure(5, 1, 3, 5, 3'b111, 6'h3F);
        run_chk(4, "R8 before");
        wr(3'd1, 2);  step();
        wr(3'd2, 0);  step();
        wr(3'd5, 0);  step();
        wr(3'd6, 0);  step();
        wr(3'd7, 0);  step();
        for (int i = 0; i < 14; i++) begin
            check_all("R8 lock", 1);
            @(negedge clk);
            step();
        end
        check_all("R8 lock", 1);
        halt();

        // R7 hold while halted, then R9 clear
        configure(9, 2, 5, 9, 3'b011, 6'h3F);
        run_chk(4, "R7 pre");
        halt();
        chk("R7 nonzero held value", int'(m != 0), 1);
        for (int i = 0; i < 5; i++) begin
            check_all("R7 halted hold", 0);
            @(negedge clk);
        end
        wr(3'd7, 0);
        m = 0;
        check_all("R9 clear", 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule